// File: doc/BRIEF.md
# Programmable Signal Crossbar with Edge-Detect Requests

This block routes a vector of on-chip trigger signals to a vector of destination lines. Each destination line has an 8-bit select code held in a register, and it carries the value of the input that the code names. Inputs pass through a two-flop synchroniser first. The routing multiplexers themselves are combinational, so a new select code takes effect in the cycle after its write.

The lowest-numbered outputs also have an edge detector. Software picks which transition counts as active: none, rising, falling or both. An active transition on the routed output sets a status flag. Through a request-type field, that flag can drive an interrupt line or a DMA request line. Software clears the flag by writing one to it. In DMA mode, the acknowledge from the DMA engine clears it instead.

Software reaches all state through a 16-bit register port with byte-lane enables. Each 16-bit register holds two byte-wide fields, and writing one byte leaves its neighbour unchanged.

Top module: `sig_xbar`

## Requirements
- R1: After reset, every select field and control field reads zero. All flags, `irq_req` and `dma_req` are low, and all outputs are low.
- R2: `sig_out[n]` equals the synchronised input whose index is in select field n. A change on `sig_in` appears on `sig_out` after the second rising clock edge. A select write takes effect right after the edge that stores it.
- R3: A select code equal to or above `N_IN` forces its output low.
- R4: Select field n lives at register address n/2. Even outputs use bits [7:0] and odd outputs use bits [15:8]. A write changes only the byte lanes whose `bus_be` bit is set (`bus_be[0]` is bits [7:0], `bus_be[1]` is bits [15:8]). Reads return the stored bytes.
- R5: Control fields for edge outputs k=0..N_EDGE-1 live at address N_OUT/2 + k/2, with the same byte-lane rule as R4. The byte layout is: bits [1:0] active-edge code, bits [3:2] request type, bit 4 status flag (read), bits [7:5] read zero.
- R6: Active-edge codes are 00 none, 01 rising, 10 falling, 11 both. The flag sets on the clock edge after the routed output shows the chosen transition, which is the third rising edge after the input change.
- R7: Writing a control byte with bit 4 set clears the flag. Writing 0 in bit 4 leaves the flag as it was. An active edge in the same cycle as a clear wins.
- R8: Request types are 00 disabled, 01 interrupt, 10 DMA (11 behaves as disabled). `irq_req[k]` is high exactly when flag k is set in interrupt mode. `dma_req[k]` is high exactly when flag k is set in DMA mode.
- R9: In DMA mode, a `dma_ack[k]` pulse clears flag k. In any other mode, `dma_ack[k]` is ignored.
- R10: One transition sets the flag only once. Once the flag is cleared, a steady output level does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sig_in | input | N_IN | Input signals, asynchronous |
| sig_out | output | N_OUT | Routed output signals |
| irq_req | output | N_EDGE | Interrupt requests from edge outputs |
| dma_req | output | N_EDGE | DMA requests from edge outputs |
| dma_ack | input | N_EDGE | DMA acknowledge, one-cycle pulse |

## Verification
A select write is visible on `sig_out` at the falling edge just after the storing clock edge. An input change is visible two rising edges later, and a flag one edge after that. The bench drives every stimulus on a falling edge and counts that many falling edges before it samples. For edge outputs it also samples one edge early, to show the flag has not yet risen. Requests and cleared flags are due in the cycle after the clearing write or acknowledge, and the bench reads them there through the register port and the request pins.

// File: rtl/sig_xbar.sv
module sig_xbar #(
  parameter int N_IN   = 20,
  parameter int N_OUT  = 8,
  parameter int N_EDGE = 4,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [N_IN-1:0]   sig_in,
  output logic [N_OUT-1:0]  sig_out,
  output logic [N_EDGE-1:0] irq_req,
  output logic [N_EDGE-1:0] dma_req,
  input  logic [N_EDGE-1:0] dma_ack
);
  localparam int CTL_BASE = (N_OUT + 1) / 2;
  localparam int PAD_W    = 1 << SEL_W;

  logic [N_IN-1:0]   meta_q, sync_q;
  logic [PAD_W-1:0]  pad;
  logic [SEL_W-1:0]  sel_q [N_OUT];
  logic [1:0]        act_q [N_EDGE];
  logic [1:0]        req_q [N_EDGE];
  logic [N_EDGE-1:0] prev_q, flag_q, hit, wr_ctl, clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= sig_in;
      sync_q <= meta_q;
    end

  assign pad = PAD_W'(sync_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int n = 0; n < N_OUT; n++) sel_q[n] <= '0;
    end else if (bus_we) begin
      for (int n = 0; n < N_OUT; n++)
        if (bus_addr == ADDR_W'(n / 2) && bus_be[n % 2])
          sel_q[n] <= bus_wdata[8*(n % 2) +: SEL_W];
    end

  always_comb
    for (int n = 0; n < N_OUT; n++) sig_out[n] = pad[sel_q[n]];

  always_comb
    for (int k = 0; k < N_EDGE; k++) begin
      wr_ctl[k]  = bus_we && bus_addr == ADDR_W'(CTL_BASE + k / 2) && bus_be[k % 2];
      hit[k]     = (sig_out[k] && !prev_q[k] && act_q[k][0]) ||
                   (!sig_out[k] && prev_q[k] && act_q[k][1]);
      clr[k]     = (wr_ctl[k] && bus_wdata[8*(k % 2) + 4]) ||
                   (dma_ack[k] && req_q[k] == 2'b10);
      irq_req[k] = flag_q[k] && req_q[k] == 2'b01;
      dma_req[k] = flag_q[k] && req_q[k] == 2'b10;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      for (int k = 0; k < N_EDGE; k++) begin
        act_q[k] <= '0;
        req_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < N_EDGE; k++) begin
        prev_q[k] <= sig_out[k];
        if (wr_ctl[k]) begin
          act_q[k] <= bus_wdata[8*(k % 2) +: 2];
          req_q[k] <= bus_wdata[8*(k % 2) + 2 +: 2];
        end
        if (hit[k])      flag_q[k] <= 1'b1;
        else if (clr[k]) flag_q[k] <= 1'b0;
      end
    end

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < N_OUT; n++)
      if (bus_addr == ADDR_W'(n / 2))
        bus_rdata[8*(n % 2) +: 8] = 8'(sel_q[n]);
    for (int k = 0; k < N_EDGE; k++)
      if (bus_addr == ADDR_W'(CTL_BASE + k / 2))
        bus_rdata[8*(k % 2) +: 8] = {3'b000, flag_q[k], req_q[k], act_q[k]};
  end

  for (genvar n = 0; n < N_OUT; n++) begin : g_out_chk
    // R3
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[n] >= SEL_W'(N_IN)) |-> !sig_out[n]);
    // R4
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_be[n % 2]) |=> $stable(sel_q[n]));
  end

  for (genvar k = 0; k < N_EDGE; k++) begin : g_edge_chk
    // R6
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[k]) |-> ($past(sig_out[k]) != $past(prev_q[k])));
    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl[k] && bus_wdata[8*(k % 2) + 4] && !hit[k]) |=> !flag_q[k]);
    // R9
    dma_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack[k] && dma_req[k] && !hit[k]) |=> !flag_q[k]);
    // R8
    irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[k] |-> (flag_q[k] && !dma_req[k]));
  end
endmodule

// File: tb/sig_xbar_bench.sv
module sig_xbar_bench;
  localparam int CLK_P  = 10;
  localparam int N_IN   = 20;
  localparam int N_OUT  = 8;
  localparam int N_EDGE = 4;
  localparam int CTL    = N_OUT / 2;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [1:0] bus_be = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [N_IN-1:0] sig_in = 0;
  logic [N_OUT-1:0] sig_out;
  logic [N_EDGE-1:0] irq_req, dma_req, dma_ack = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sig_xbar u_sig_xbar (.clk, .rst_n, .bus_we, .bus_be, .bus_addr, .bus_wdata, .bus_rdata,
                       .sig_in, .sig_out, .irq_req, .dma_req, .dma_ack);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    bus_we = 1; bus_addr = 4'(a); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_we = 0; bus_be = 0;
  endtask

  task automatic rd(int a, output logic [15:0] v);
    bus_addr = 4'(a);
    #1 v = bus_rdata;
  endtask

  function automatic logic [15:0] lane(int k, logic [7:0] b);
    return (k % 2) ? {b, 8'h00} : {8'h00, b};
  endfunction

  task automatic flag_of(int k, output logic f);
    logic [15:0] v;
    rd(CTL + k / 2, v);
    f = v[8*(k % 2) + 4];
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] v;
    logic f;
    logic [N_IN-1:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < CTL + N_EDGE / 2; a++) begin
      rd(a, v);
      chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 outputs", {sig_out, irq_req, dma_req}, 0);

    // R2 R3 exhaustive routing sweep, two complementary input patterns
    for (int p = 0; p < 2; p++) begin
      pat = p ? ~20'h9B36D : 20'h9B36D;
      @(negedge clk); sig_in = pat;
      repeat (2) @(negedge clk);
      for (int o = 0; o < N_OUT; o++)
        for (int s = 0; s < 256; s++) begin
          wr(o / 2, lane(o, 8'(s)), (o % 2) ? 2'b10 : 2'b01);
          chk($sformatf("%s out %0d sel %0d", s < N_IN ? "R2" : "R3", o, s),
              32'(sig_out[o]), s < N_IN ? 32'(pat[s]) : 0);
        end
    end

    // R2 input latency: out changes after the second edge, not the first
    wr(0, 16'h0100, 2'b11);
    @(negedge clk); sig_in = 20'h0;
    repeat (2) @(negedge clk);
    @(negedge clk); sig_in = 20'h00002;
    @(negedge clk);
    chk("R2 not after one edge", 32'(sig_out[1]), 0);
    @(negedge clk);
    chk("R2 after two edges", 32'(sig_out[1]), 1);

    // R4 byte-lane packing
    wr(2, 16'h1234, 2'b11);
    wr(2, 16'hEEFF, 2'b01);
    rd(2, v); chk("R4 low lane only", v, 16'h12FF);
    wr(2, 16'hABCD, 2'b10);
    rd(2, v); chk("R4 high lane only", v, 16'hABFF);
    wr(2, 16'h5555, 2'b00);
    rd(2, v); chk("R4 no lane", v, 16'hABFF);

    // R5 control layout readback
    wr(CTL, 16'hFFFF, 2'b11);
    rd(CTL, v); chk("R5 ctrl layout", v, 16'h0F0F);
    wr(CTL, 16'h0000, 2'b11);
    wr(CTL + 1, 16'h0000, 2'b11);

    // route output k to input k, inputs idle low
    @(negedge clk); sig_in = 0;
    repeat (2) @(negedge clk);
    wr(0, 16'h0100, 2'b11);
    wr(1, 16'h0302, 2'b11);

    // R6 R7 R8 every edge code on every edge output, with interrupt request
    for (int k = 0; k < N_EDGE; k++)
      for (int m = 0; m < 4; m++) begin
        wr(CTL + k / 2, lane(k, 8'(8'h10 | 8'(m) | 8'h04)), (k % 2) ? 2'b10 : 2'b01);
        for (int dir = 0; dir < 2; dir++) begin
          @(negedge clk); sig_in[k] = (dir == 0);
          repeat (2) @(negedge clk);
          flag_of(k, f);
          chk($sformatf("R6 early k%0d m%0d d%0d", k, m, dir), 32'(f), 0);
          @(negedge clk);
          flag_of(k, f);
          chk($sformatf("R6 flag k%0d m%0d d%0d", k, m, dir), 32'(f), 32'((m >> dir) & 1));
          chk($sformatf("R8 irq k%0d m%0d d%0d", k, m, dir),
              {31'(dma_req[k]), irq_req[k]}, 32'((m >> dir) & 1));
          wr(CTL + k / 2, lane(k, 8'(8'h14 | 8'(m))), (k % 2) ? 2'b10 : 2'b01);
          flag_of(k, f);
          chk($sformatf("R7 clear k%0d m%0d d%0d", k, m, dir), 32'(f), 0);
        end
      end

    // R10 steady level after clear does not set again; R7 zero write keeps flag
    wr(CTL, 16'h0011, 2'b01);
    @(negedge clk); sig_in[0] = 1;
    repeat (3) @(negedge clk);
    wr(CTL, 16'h0011, 2'b01);
    repeat (6) @(negedge clk);
    flag_of(0, f); chk("R10 no re-set on level", 32'(f), 0);
    @(negedge clk); sig_in[0] = 0;
    repeat (3) @(negedge clk);
    @(negedge clk); sig_in[0] = 1;
    repeat (3) @(negedge clk);
    wr(CTL, 16'h0001, 2'b01);
    flag_of(0, f); chk("R7 write zero keeps flag", 32'(f), 1);
    chk("R8 disabled mode no request", {irq_req[0], dma_req[0]}, 0);

    // R8 R9 DMA mode and acknowledge
    wr(CTL, 16'h0009, 2'b01);
    chk("R8 dma request", {irq_req[0], dma_req[0]}, 1);
    @(negedge clk); dma_ack[0] = 1;
    @(negedge clk); dma_ack[0] = 0;
    flag_of(0, f); chk("R9 ack clears", 32'(f), 0);
    chk("R9 request drops", 32'(dma_req[0]), 0);

    // R9 ack ignored in interrupt mode
    wr(CTL, 16'h0005, 2'b01);
    @(negedge clk); sig_in[0] = 0;
    repeat (3) @(negedge clk);
    @(negedge clk); sig_in[0] = 1;
    repeat (3) @(negedge clk);
    @(negedge clk); dma_ack[0] = 1;
    @(negedge clk); dma_ack[0] = 0;
    flag_of(0, f); chk("R9 ack ignored irq mode", 32'(f), 1);
    chk("R8 irq held", 32'(irq_req[0]), 1);

    done = 1;
    summary();
  end
endmodule